// File: doc/BRIEF.md
# Pulse Program Sequencer

This block steps through a stored program of wide instruction words and turns it into a timed 24-bit output pattern. Every word carries an output value, a four-bit operation code, a 20-bit argument and a delay length counted in clock ticks. When a word is issued, its output value reaches the output bus at once and stays there for the word's delay. Then the operation decides which address comes next. The operations are: plain continue, scaled delay, counted loop start and loop end, branch, subroutine call and return, wait-for-trigger, and halt.

The program sits in an external synchronous memory with one read port: data returns one cycle after the address. While the current word's delay runs, the sequencer reads the next word into a one-word prefetch register. As a result, consecutive words follow each other with no idle cycle. A start pulse restarts execution at address 0 from the idle or halted state, and a trigger pulse also does this straight after reset. The trigger input also releases a waiting word. Status pins report whether the sequencer is running, waiting or halted. Two sticky flags report a clamped delay and a stack fault.

The memory port is a plain request/data port with a fixed one-cycle latency and no back-pressure: the memory must answer every request. The remaining pins are plain level or pulse control signals.

Top module: `pps_seq_core`

## Requirements
- R1: After reset, the output bus is 0, `stopped_o` is 1, `running_o`, `waiting_o`, `imem_en_o`, `fault_o` and `len_err_o` are 0, and exactly one of the three status flags is high in every cycle.
- R2: A start pulse sampled at edge s from the idle or halted state raises `imem_en_o` with address 0 in the following cycle. The output value of word 0 appears at edge s+3.
- R3: The word layout is: output value in bits [23:0], operation in [27:24], argument in [47:28], delay in [63:48]. A non-halting word holds its output value for exactly its delay in cycles, and the next word's value follows with no gap.
- R4: A delay below MIN_LEN (default 3) is executed as MIN_LEN and sets the sticky `len_err_o`.
- R5: Operation 7 (scaled delay) holds the output for argument × delay cycles. An argument of 0 or 1 gives a single delay.
- R6: Operation 6 (branch) continues at the address held in the argument.
- R7: Operation 4 (call) saves its own address + 1 on a return stack of CALL_DEPTH (8) entries and jumps to the argument. Operation 5 (return) continues at the most recently saved address.
- R8: Operation 2 (loop start) with count n, paired with operation 3 (loop end) whose argument is the loop-start address, runs the loop-start word and the loop-end word n times each. Loops nest up to LOOP_DEPTH (8) levels, and a count of 0 acts as 1.
- R9: Operation 8 (wait) drives its output, holds it with `waiting_o` high until `trig_i` is sampled, and then holds it for its delay. A trigger sampled D cycles after the issue edge therefore yields D + delay cycles.
- R10: Operation 1 (halt) ignores its output and delay fields, keeps the previous output and raises `stopped_o`. A later start restarts from address 0, and straight after reset a trigger pulse also starts execution.
- R11: A call with a full return stack, a return with an empty one, a loop start with a full loop stack, or a loop end with no open loop sets the sticky `fault_o` and halts, leaving the output unchanged.
- R12: Operation 0 and every undefined code (9 to 15) act as plain continue to the next address.
- R13: Each word is read with a single one-cycle `imem_en_o` pulse. The next word is always present in the prefetch register by the time the current delay ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start pulse; begins execution at address 0 when idle or halted |
| trig_i | input | 1 | Trigger pulse; releases a waiting word, starts execution right after reset |
| imem_en_o | output | 1 | Instruction memory read request |
| imem_addr_o | output | AW (10) | Instruction memory read address |
| imem_rdata_i | input | 64 | Instruction word, valid the cycle after the request |
| out_o | output | 24 | Pattern output bus |
| running_o | output | 1 | Fetching or executing |
| waiting_o | output | 1 | Waiting for a trigger |
| stopped_o | output | 1 | Idle after reset or halted |
| len_err_o | output | 1 | Sticky: a delay was clamped to the minimum |
| fault_o | output | 1 | Sticky: return or loop stack misuse |

## Verification
The assertions check the cycle-level rules on every cycle. They cover the single status flag, the held output while halted or waiting, the stickiness of both error flags, the one-cycle memory request, the prefetch word being ready when a delay ends, and the stacks never being pushed when full or popped when empty. Exact delay counts, the order of branch, call, return and nested-loop sequences, scaled-delay lengths, wait timing relative to the trigger, and restart after halt can only be shown by the bench. It runs whole programs against a scoreboard of expected output segments and their lengths.

// File: rtl/pps_pkg.sv
package pps_pkg;

  typedef enum logic [3:0] {
    OP_CONT    = 4'd0,
    OP_STOP    = 4'd1,
    OP_LOOP    = 4'd2,
    OP_ENDLOOP = 4'd3,
    OP_CALL    = 4'd4,
    OP_RETURN  = 4'd5,
    OP_GOTO    = 4'd6,
    OP_LONGDLY = 4'd7,
    OP_WAIT    = 4'd8
  } op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH,
    ST_RUN,
    ST_WAIT,
    ST_HALT
  } st_e;

endpackage

// File: rtl/pps_lifo.sv
module pps_lifo #(
  parameter int DW    = 10,
  parameter int DEPTH = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_i,
  input  logic          push_i,
  input  logic          pop_i,
  input  logic          wr_top_i,
  input  logic [DW-1:0] din_i,
  output logic [DW-1:0] top_o,
  output logic          empty_o,
  output logic          full_o
);
  localparam int CW = $clog2(DEPTH + 1);
  localparam int IW = $clog2(DEPTH);

  logic [DW-1:0] mem_q [DEPTH];
  logic [CW-1:0] cnt_q;
  logic [IW-1:0] top_idx;
  logic [IW-1:0] put_idx;

  assign top_idx = IW'(cnt_q - 1'b1);
  assign put_idx = IW'(cnt_q);
  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CW'(DEPTH));
  assign top_o   = empty_o ? '0 : mem_q[top_idx];

  always_ff @(posedge clk) begin
    if (!rst_n || clr_i) begin
      cnt_q <= '0;
    end else if (push_i) begin
      cnt_q <= cnt_q + 1'b1;
    end else if (pop_i) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (push_i) begin
      mem_q[put_idx] <= din_i;
    end else if (wr_top_i) begin
      mem_q[top_idx] <= din_i;
    end
  end

  // R11: the sequencer turns misuse into a fault, never into a bad stack access
  a_r11_no_push_full : assert property (@(posedge clk) disable iff (!rst_n)
    push_i |-> !full_o);
  a_r11_no_pop_empty : assert property (@(posedge clk) disable iff (!rst_n)
    (pop_i || wr_top_i) |-> !empty_o);

endmodule

// File: rtl/pps_timer.sv
module pps_timer #(
  parameter int LEN_W = 16,
  parameter int REP_W = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic [REP_W-1:0] rep_i,
  output logic             last_o
);
  logic             active_q;
  logic [LEN_W-1:0] cnt_q;
  logic [LEN_W-1:0] len_q;
  logic [REP_W-1:0] rep_q;

  assign last_o = active_q && (cnt_q == '0) && (rep_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
      len_q    <= '0;
      rep_q    <= '0;
    end else if (load_i) begin
      active_q <= 1'b1;
      cnt_q    <= len_i - 1'b1;
      len_q    <= len_i;
      rep_q    <= rep_i;
    end else if (active_q) begin
      if (cnt_q != '0) begin
        cnt_q <= cnt_q - 1'b1;
      end else if (rep_q != '0) begin
        rep_q <= rep_q - 1'b1;
        cnt_q <= len_q - 1'b1;
      end else begin
        active_q <= 1'b0;
      end
    end
  end

  // R3: the end of a delay lasts one cycle unless a new delay is loaded
  a_r3_last_single : assert property (@(posedge clk) disable iff (!rst_n)
    (last_o && !load_i) |=> !last_o);

endmodule

// File: rtl/pps_seq_core.sv
module pps_seq_core
  import pps_pkg::*;
#(
  parameter int OUT_W      = 24,
  parameter int ARG_W      = 20,
  parameter int LEN_W      = 16,
  parameter int AW         = 10,
  parameter int CALL_DEPTH = 8,
  parameter int LOOP_DEPTH = 8,
  parameter int MIN_LEN    = 3
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             start_i,
  input  logic                             trig_i,
  output logic                             imem_en_o,
  output logic [AW-1:0]                    imem_addr_o,
  input  logic [OUT_W+4+ARG_W+LEN_W-1:0]   imem_rdata_i,
  output logic [OUT_W-1:0]                 out_o,
  output logic                             running_o,
  output logic                             waiting_o,
  output logic                             stopped_o,
  output logic                             len_err_o,
  output logic                             fault_o
);
  localparam int OPC_W   = 4;
  localparam int IW      = OUT_W + OPC_W + ARG_W + LEN_W;
  localparam int OPC_LSB = OUT_W;
  localparam int ARG_LSB = OPC_LSB + OPC_W;
  localparam int LEN_LSB = ARG_LSB + ARG_W;
  localparam int LOOP_W  = AW + ARG_W;

  st_e              st_q;
  logic [IW-1:0]    pf_q;
  logic             pf_vld_q;
  logic             fetch_req_q;
  logic             rd_vld_q;
  logic [AW-1:0]    fetch_addr_q;
  logic [OUT_W-1:0] out_q;
  logic [LEN_W-1:0] wait_len_q;
  logic             fault_q;
  logic             lerr_q;

  // fields of the prefetched word
  logic [OUT_W-1:0] w_out;
  op_e              w_op;
  logic [ARG_W-1:0] w_arg;
  logic [LEN_W-1:0] w_len;
  logic [AW-1:0]    w_tgt;
  logic [AW-1:0]    seq_addr;
  logic [LEN_W-1:0] len_c;
  logic             len_short;

  assign w_out     = pf_q[OUT_W-1:0];
  assign w_op      = op_e'(pf_q[OPC_LSB +: OPC_W]);
  assign w_arg     = pf_q[ARG_LSB +: ARG_W];
  assign w_len     = pf_q[LEN_LSB +: LEN_W];
  assign w_tgt     = w_arg[AW-1:0];
  assign seq_addr  = fetch_addr_q + 1'b1;
  assign len_short = (w_len < LEN_W'(MIN_LEN));
  assign len_c     = len_short ? LEN_W'(MIN_LEN) : w_len;

  // stacks
  logic              cs_push, cs_pop, cs_empty, cs_full;
  logic [AW-1:0]     cs_top;
  logic              ls_push, ls_pop, ls_wr, ls_empty, ls_full;
  logic [LOOP_W-1:0] ls_din, ls_top;
  logic [AW-1:0]     ls_top_tag;
  logic [ARG_W-1:0]  ls_top_cnt;

  assign ls_top_tag = ls_top[LOOP_W-1:ARG_W];
  assign ls_top_cnt = ls_top[ARG_W-1:0];

  // timer
  logic             tmr_load, tmr_last;
  logic [LEN_W-1:0] tmr_len;
  logic [ARG_W-1:0] tmr_rep;

  // decode
  logic             issue, go;
  logic             d_cs_push, d_cs_pop, d_ls_push, d_ls_pop, d_ls_wr;
  logic             d_fault, d_halt, d_wait;
  logic [AW-1:0]    d_next;
  logic [ARG_W-1:0] d_rep;
  logic [ARG_W-1:0] loop_cnt;

  assign loop_cnt = (w_arg == '0) ? ARG_W'(1) : w_arg;

  assign issue = pf_vld_q && ((st_q == ST_FETCH) || ((st_q == ST_RUN) && tmr_last));
  assign go    = (start_i && ((st_q == ST_IDLE) || (st_q == ST_HALT))) ||
                 (trig_i && (st_q == ST_IDLE));

  always_comb begin
    d_next    = seq_addr;
    d_cs_push = 1'b0;
    d_cs_pop  = 1'b0;
    d_ls_push = 1'b0;
    d_ls_pop  = 1'b0;
    d_ls_wr   = 1'b0;
    ls_din    = '0;
    d_fault   = 1'b0;
    d_halt    = 1'b0;
    d_wait    = 1'b0;
    d_rep     = '0;
    case (w_op)
      OP_STOP: d_halt = 1'b1;
      OP_GOTO: d_next = w_tgt;
      OP_CALL: begin
        if (cs_full) d_fault = 1'b1;
        else begin
          d_cs_push = 1'b1;
          d_next    = w_tgt;
        end
      end
      OP_RETURN: begin
        if (cs_empty) d_fault = 1'b1;
        else begin
          d_cs_pop = 1'b1;
          d_next   = cs_top;
        end
      end
      OP_LOOP: begin
        if (ls_empty || (ls_top_tag != fetch_addr_q)) begin
          if (ls_full) d_fault = 1'b1;
          else begin
            d_ls_push = 1'b1;
            ls_din    = {fetch_addr_q, loop_cnt};
          end
        end
      end
      OP_ENDLOOP: begin
        if (ls_empty) d_fault = 1'b1;
        else if (ls_top_cnt > ARG_W'(1)) begin
          d_ls_wr = 1'b1;
          ls_din  = {ls_top_tag, ls_top_cnt - 1'b1};
          d_next  = w_tgt;
        end else begin
          d_ls_pop = 1'b1;
        end
      end
      OP_LONGDLY: d_rep = (w_arg == '0) ? '0 : w_arg - 1'b1;
      OP_WAIT:    d_wait = 1'b1;
      default:    ;
    endcase
  end

  assign cs_push = issue && d_cs_push;
  assign cs_pop  = issue && d_cs_pop;
  assign ls_push = issue && d_ls_push;
  assign ls_pop  = issue && d_ls_pop;
  assign ls_wr   = issue && d_ls_wr;

  assign tmr_load = (issue && !d_halt && !d_fault && !d_wait) ||
                    ((st_q == ST_WAIT) && trig_i);
  assign tmr_len  = (st_q == ST_WAIT) ? wait_len_q : len_c;
  assign tmr_rep  = (st_q == ST_WAIT) ? '0 : d_rep;

  pps_lifo #(.DW(AW), .DEPTH(CALL_DEPTH)) u_call_stack (
    .clk(clk), .rst_n(rst_n), .clr_i(go),
    .push_i(cs_push), .pop_i(cs_pop), .wr_top_i(1'b0),
    .din_i(seq_addr), .top_o(cs_top), .empty_o(cs_empty), .full_o(cs_full)
  );

  pps_lifo #(.DW(LOOP_W), .DEPTH(LOOP_DEPTH)) u_loop_stack (
    .clk(clk), .rst_n(rst_n), .clr_i(go),
    .push_i(ls_push), .pop_i(ls_pop), .wr_top_i(ls_wr),
    .din_i(ls_din), .top_o(ls_top), .empty_o(ls_empty), .full_o(ls_full)
  );

  pps_timer #(.LEN_W(LEN_W), .REP_W(ARG_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .load_i(tmr_load),
    .len_i(tmr_len), .rep_i(tmr_rep), .last_o(tmr_last)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q         <= ST_IDLE;
      pf_q         <= '0;
      pf_vld_q     <= 1'b0;
      fetch_req_q  <= 1'b0;
      rd_vld_q     <= 1'b0;
      fetch_addr_q <= '0;
      out_q        <= '0;
      wait_len_q   <= '0;
      fault_q      <= 1'b0;
      lerr_q       <= 1'b0;
    end else begin
      fetch_req_q <= 1'b0;
      rd_vld_q    <= fetch_req_q;
      if (rd_vld_q) begin
        pf_q     <= imem_rdata_i;
        pf_vld_q <= 1'b1;
      end
      if (go) begin
        st_q         <= ST_FETCH;
        fetch_addr_q <= '0;
        fetch_req_q  <= 1'b1;
        pf_vld_q     <= 1'b0;
      end else if (issue) begin
        pf_vld_q <= 1'b0;
        if (d_fault) begin
          fault_q <= 1'b1;
          st_q    <= ST_HALT;
        end else if (d_halt) begin
          st_q <= ST_HALT;
        end else begin
          out_q        <= w_out;
          lerr_q       <= lerr_q | len_short;
          fetch_addr_q <= d_next;
          fetch_req_q  <= 1'b1;
          if (d_wait) begin
            st_q       <= ST_WAIT;
            wait_len_q <= len_c;
          end else begin
            st_q <= ST_RUN;
          end
        end
      end else if ((st_q == ST_WAIT) && trig_i) begin
        st_q <= ST_RUN;
      end
    end
  end

  assign imem_en_o   = fetch_req_q;
  assign imem_addr_o = fetch_addr_q;
  assign out_o       = out_q;
  assign running_o   = (st_q == ST_FETCH) || (st_q == ST_RUN);
  assign waiting_o   = (st_q == ST_WAIT);
  assign stopped_o   = (st_q == ST_IDLE) || (st_q == ST_HALT);
  assign len_err_o   = lerr_q;
  assign fault_o     = fault_q;

  // R1: exactly one status flag
  a_r1_one_status : assert property (@(posedge clk) disable iff (!rst_n)
    $onehot({running_o, waiting_o, stopped_o}));
  // R10: a halted sequencer keeps its output
  a_r10_halt_hold : assert property (@(posedge clk) disable iff (!rst_n)
    (stopped_o && !start_i && !trig_i) |=> $stable(out_o));
  // R9: waiting holds the output until a trigger
  a_r9_wait_hold : assert property (@(posedge clk) disable iff (!rst_n)
    (waiting_o && !trig_i) |=> (waiting_o && $stable(out_o)));
  // R13: the next word is present when the delay ends
  a_r13_prefetch_ready : assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == ST_RUN) && tmr_last) |-> pf_vld_q);
  // R13: one-cycle read requests
  a_r13_single_read : assert property (@(posedge clk) disable iff (!rst_n)
    imem_en_o |=> !imem_en_o);
  // R11: fault is sticky
  a_r11_fault_sticky : assert property (@(posedge clk) disable iff (!rst_n)
    fault_o |=> fault_o);
  // R4: clamp flag is sticky
  a_r4_err_sticky : assert property (@(posedge clk) disable iff (!rst_n)
    len_err_o |=> len_err_o);

endmodule

// File: tb/pps_seq_core_tb.sv
module pps_seq_core_tb_top;
  import pps_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic        trig_i = 1'b0;
  logic        imem_en_o;
  logic [9:0]  imem_addr_o;
  logic [63:0] imem_rdata_i = '0;
  logic [23:0] out_o;
  logic        running_o, waiting_o, stopped_o, len_err_o, fault_o;

  always #10 clk = ~clk;

  pps_seq_core dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .trig_i(trig_i),
    .imem_en_o(imem_en_o), .imem_addr_o(imem_addr_o), .imem_rdata_i(imem_rdata_i),
    .out_o(out_o), .running_o(running_o), .waiting_o(waiting_o),
    .stopped_o(stopped_o), .len_err_o(len_err_o), .fault_o(fault_o)
  );

  logic [63:0] mem [0:1023];
  always @(posedge clk) if (imem_en_o) imem_rdata_i <= mem[imem_addr_o];

  int checks = 0;
  int errors = 0;

  // scoreboard of expected output segments
  logic [23:0] exp_val_q [$];
  int          exp_len_q [$];
  string       exp_req_q [$];
  bit          armed = 0;
  bit          first = 0;
  logic [23:0] cur_val;
  int          cur_len;

  function automatic logic [63:0] mk(logic [23:0] o, logic [3:0] op, logic [19:0] a, logic [15:0] l);
    return {l, a, op, o};
  endfunction

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic push_seg(logic [23:0] v, int n, string req);
    exp_val_q.push_back(v);
    exp_len_q.push_back(n);
    exp_req_q.push_back(req);
  endtask

  // monitor: closes a segment whenever the output changes
  always @(negedge clk) begin
    if (armed) begin
      if (out_o !== cur_val) begin
        if (!first) begin
          if (exp_val_q.size() == 0) begin
            check(1'b0, "R3", "unexpected segment value", cur_val, 0);
          end else begin
            logic [23:0] ev;
            int          el;
            string       er;
            ev = exp_val_q.pop_front();
            el = exp_len_q.pop_front();
            er = exp_req_q.pop_front();
            check(cur_val == ev, er, "segment value", cur_val, ev);
            check(cur_len == el, er, "segment length", cur_len, el);
          end
        end
        first   = 0;
        cur_val = out_o;
        cur_len = 1;
      end else begin
        cur_len++;
      end
    end
  end

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; start_i = 1'b0; trig_i = 1'b0;
    armed = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic clear_mem();
    for (int i = 0; i < 1024; i++) mem[i] = '0;
  endtask

  task automatic arm();
    cur_val = out_o;
    cur_len = 0;
    first   = 1;
    armed   = 1;
  endtask

  task automatic pulse_start();
    arm();
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic wait_halt(string req);
    int n = 0;
    while (!stopped_o && n < 5000) begin
      @(negedge clk);
      n++;
    end
    check(n < 5000, req, "halt reached", n, 0);
    repeat (2) @(negedge clk);
    armed = 0;
    check(exp_val_q.size() == 0, req, "segments left", exp_val_q.size(), 0);
    exp_val_q.delete(); exp_len_q.delete(); exp_req_q.delete();
  endtask

  task automatic wait_prog_run(string req);
    int n;
    pulse_start();
    n = 0;
    while (!waiting_o && n < 1000) begin
      @(negedge clk);
      n++;
    end
    check(waiting_o == 1'b1, req, "waiting flag", waiting_o, 1);
    repeat (5) @(negedge clk);
    check(out_o == 24'h0000B2 && waiting_o, req, "held while waiting", out_o, 24'h0000B2);
    trig_i = 1'b1;
    @(negedge clk);
    trig_i = 1'b0;
    wait_halt(req);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "R1", "watchdog expired", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // R1 reset state
    clear_mem();
    do_reset();
    check(out_o == 0, "R1", "reset out", out_o, 0);
    check(stopped_o && !running_o && !waiting_o, "R1", "reset status",
          {running_o, waiting_o, stopped_o}, 3'b001);
    check(!imem_en_o && !fault_o && !len_err_o, "R1", "reset flags",
          {imem_en_o, fault_o, len_err_o}, 0);

    // T1: R2 R3 R6 R12 R13 - start latency, plain words, undefined code, branch
    mem[0] = mk(24'h0000A1, OP_CONT, 0, 5);
    mem[1] = mk(24'h0000A2, 4'hF,    0, 3);   // R12 undefined code
    mem[2] = mk(24'h0000A3, OP_GOTO, 5, 4);   // R6
    mem[3] = mk(24'h0000EE, OP_CONT, 0, 3);
    mem[5] = mk(24'h0000A4, OP_CONT, 0, 3);
    mem[6] = mk(24'h000000, OP_STOP, 0, 0);
    push_seg(24'h0000A1, 5, "R3");
    push_seg(24'h0000A2, 3, "R12");
    push_seg(24'h0000A3, 4, "R6");
    pulse_start();
    check(imem_en_o && imem_addr_o == 0 && running_o, "R2", "first fetch",
          {imem_en_o, imem_addr_o}, {1'b1, 10'd0});
    @(negedge clk);
    check(!imem_en_o, "R13", "single read pulse", imem_en_o, 0);
    check(out_o == 0, "R2", "out before s+3", out_o, 0);
    @(negedge clk);
    check(out_o == 0, "R2", "out before s+3", out_o, 0);
    @(negedge clk);
    check(out_o == 24'h0000A1, "R2", "word 0 at s+3", out_o, 24'h0000A1);
    wait_halt("R6");
    check(out_o == 24'h0000A4, "R10", "halt keeps out", out_o, 24'h0000A4);
    check(!len_err_o && !fault_o, "R4", "no clamp flag", len_err_o, 0);

    // T2: R5 R4 scaled delay and clamp
    clear_mem();
    do_reset();
    mem[0] = mk(24'h0000C1, OP_LONGDLY, 4, 3);
    mem[1] = mk(24'h0000C2, OP_LONGDLY, 1, 5);
    mem[2] = mk(24'h0000C3, OP_CONT,    0, 1);
    mem[3] = mk(24'h0000C4, OP_LONGDLY, 0, 4);
    mem[4] = mk(24'h000000, OP_STOP,    0, 0);
    push_seg(24'h0000C1, 12, "R5");
    push_seg(24'h0000C2, 5,  "R5");
    push_seg(24'h0000C3, 3,  "R4");
    pulse_start();
    wait_halt("R5");
    check(out_o == 24'h0000C4, "R5", "last out", out_o, 24'h0000C4);
    check(len_err_o == 1'b1, "R4", "clamp flag", len_err_o, 1);

    // T3: R7 call/return
    clear_mem();
    do_reset();
    mem[0]  = mk(24'h0000D1, OP_CALL,   10, 3);
    mem[1]  = mk(24'h0000D2, OP_CALL,   10, 4);
    mem[2]  = mk(24'h000000, OP_STOP,   0,  0);
    mem[10] = mk(24'h0000D3, OP_CONT,   0,  3);
    mem[11] = mk(24'h0000D4, OP_RETURN, 0,  5);
    push_seg(24'h0000D1, 3, "R7");
    push_seg(24'h0000D3, 3, "R7");
    push_seg(24'h0000D4, 5, "R7");
    push_seg(24'h0000D2, 4, "R7");
    push_seg(24'h0000D3, 3, "R7");
    pulse_start();
    wait_halt("R7");
    check(out_o == 24'h0000D4 && !fault_o, "R7", "return then halt", out_o, 24'h0000D4);

    // T4: R8 nested loops
    clear_mem();
    do_reset();
    mem[0] = mk(24'h000011, OP_LOOP,    3, 3);
    mem[1] = mk(24'h000012, OP_LOOP,    2, 3);
    mem[2] = mk(24'h000013, OP_ENDLOOP, 1, 4);
    mem[3] = mk(24'h000014, OP_ENDLOOP, 0, 3);
    mem[4] = mk(24'h000000, OP_STOP,    0, 0);
    for (int k = 0; k < 3; k++) begin
      push_seg(24'h000011, 3, "R8");
      push_seg(24'h000012, 3, "R8");
      push_seg(24'h000013, 4, "R8");
      push_seg(24'h000012, 3, "R8");
      push_seg(24'h000013, 4, "R8");
      if (k < 2) push_seg(24'h000014, 3, "R8");
    end
    pulse_start();
    wait_halt("R8");
    check(out_o == 24'h000014 && !fault_o, "R8", "loop exit", out_o, 24'h000014);

    // T5: R9 wait, then R10 restart after halt
    clear_mem();
    do_reset();
    mem[0] = mk(24'h0000B1, OP_CONT, 0, 3);
    mem[1] = mk(24'h0000B2, OP_WAIT, 0, 4);
    mem[2] = mk(24'h0000B3, OP_CONT, 0, 3);
    mem[3] = mk(24'h000000, OP_STOP, 0, 0);
    push_seg(24'h0000B1, 3,  "R9");
    push_seg(24'h0000B2, 10, "R9");
    wait_prog_run("R9");
    check(out_o == 24'h0000B3, "R9", "after wait", out_o, 24'h0000B3);
    repeat (10) @(negedge clk);
    check(out_o == 24'h0000B3 && stopped_o, "R10", "halt holds", out_o, 24'h0000B3);
    push_seg(24'h0000B1, 3,  "R10");
    push_seg(24'h0000B2, 10, "R10");
    wait_prog_run("R10");
    check(out_o == 24'h0000B3, "R10", "restart result", out_o, 24'h0000B3);

    // T6: R11 return on empty stack
    clear_mem();
    do_reset();
    mem[0] = mk(24'h0000F1, OP_CONT,   0, 3);
    mem[1] = mk(24'h0000F2, OP_RETURN, 0, 3);
    pulse_start();
    wait_halt("R11");
    check(fault_o && out_o == 24'h0000F1, "R11", "underflow fault", out_o, 24'h0000F1);

    // T7: R11 call overflow
    clear_mem();
    do_reset();
    mem[0] = mk(24'h0000F3, OP_CALL, 0, 3);
    pulse_start();
    wait_halt("R11");
    check(fault_o && out_o == 24'h0000F3 && stopped_o, "R11", "overflow fault", fault_o, 1);

    // T8: R10 trigger start straight after reset
    clear_mem();
    do_reset();
    mem[0] = mk(24'h000071, OP_CONT, 0, 3);
    mem[1] = mk(24'h000000, OP_STOP, 0, 0);
    arm();
    trig_i = 1'b1;
    @(negedge clk);
    trig_i = 1'b0;
    check(running_o == 1'b1, "R10", "trigger start", running_o, 1);
    wait_halt("R10");
    check(out_o == 24'h000071, "R10", "trigger-started run", out_o, 24'h000071);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule